// File: doc/BRIEF.md
# Delayed Write Completion and Parity Error Handler

This block models one interface of a bus bridge that completes writes in delayed fashion. A write is first posted into a single-entry record that holds its address, command, data and byte enables. The far-side target then completes the write and reports its completion status, which may carry a data parity error. Until the initiator repeats the identical write, the record stays in place. Each repeated attempt is compared with the record, and the block answers it with one of three outcomes: a retry, a completion, or a parity-error acceptance that keeps the record queued.

Parity reporting runs through a delayed error strobe and three sticky status bits. The strobe fires two cycles after the cycle in which the block accepts the data phase. The status bits record a parity error detected on this interface, a parity error detected on the target side, and a system error. A master-timeout counter frees a stale record when no matching attempt arrives within a programmable number of cycles.

The controller has three states. In S_IDLE the record is empty. In S_PEND the record is queued and the target has not yet completed. In S_READY the completion status is held for the initiator. The transitions are:
- load: S_IDLE to S_PEND.
- target_done: S_PEND to S_READY.
- complete: S_READY to S_IDLE.
- expire: S_PEND or S_READY to S_IDLE.

A parity-error acceptance keeps the controller in S_READY.

Top module: `dwr_parity_ctl`

## Requirements
- R1: A `wr_load` pulse while no record is queued stores the address, command, data and byte enables, and `q_full_o` is 1 from the next cycle. A `wr_load` while a record is queued is ignored, and the stored record does not change.
- R2: An attempt completes only when all four of its fields (address, command, data, byte enables) equal the stored ones. Parity is never part of this comparison. A difference in any single field makes the attempt a mismatch.
- R3: An attempt that mismatches, arrives before the target has completed, or arrives with no record queued gives `retry_o`=1 and `trdy_o`=0 one cycle later. The record stays queued.
- R4: A matching attempt in S_READY with `att_par_err`=1 gives `trdy_o`=1 one cycle later. The write status is withheld and `q_full_o` stays 1. A matching attempt with `att_par_err`=0 gives `trdy_o`=1 and frees the record (`q_full_o`=0 next cycle).
- R5: After a parity-error acceptance, `perr_o` is 1 exactly two cycles after the `trdy_o` cycle, but only when `en_resp_init`=1. With `en_resp_init`=0, `perr_o` stays 0.
- R6: A parity-error acceptance sets `par_det_o` in the same cycle that `trdy_o` rises, whatever the value of `en_resp_init`.
- R7: `tgt_done` in S_PEND with `tgt_perr`=1 sets `dpar_det_o` one cycle later, but only when `en_resp_tgt`=1. The error is latched for forwarding in either case.
- R8: A normal completion whose target status carried a parity error gives `perr_o`=1 two cycles after `trdy_o`, but only when both `en_resp_init` and `en_resp_tgt` are 1. The record is freed either way.
- R9: `perr_o` is high for exactly one cycle. An event that arrives while the two-cycle delay is still counting produces no strobe.
- R10: While a record is queued, a counter restarts on the load and on each parity-error acceptance. When it reaches `tmo_limit`, the next edge frees the record and sets `serr_o`. With a load at the edge that ends cycle N, `q_full_o` is 1 in cycle N+1+`tmo_limit` and 0 in cycle N+2+`tmo_limit`.
- R11: `par_det_o`, `dpar_det_o` and `serr_o` stay set until a one-cycle pulse on `clr_det`, `clr_dpd` or `clr_serr`, respectively, clears them. A new set event takes priority over a clear in the same cycle.
- R12: After reset all outputs are 0. `trdy_o` and `retry_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_resp_init | input | 1 | Parity-error response enable of this interface |
| en_resp_tgt | input | 1 | Parity-error response enable of the target-side interface |
| tmo_limit | input | TW | Master-timeout limit in cycles |
| wr_load | input | 1 | Post a new delayed write into the record |
| wr_addr | input | AW | Address of posted write |
| wr_cmd | input | CW | Command of posted write |
| wr_data | input | DW | Data of posted write |
| wr_be | input | BW | Byte enables of posted write |
| tgt_done | input | 1 | Target side finished the write |
| tgt_perr | input | 1 | Target reported a data parity error with `tgt_done` |
| att_valid | input | 1 | Initiator repeats a write this cycle |
| att_addr | input | AW | Attempt address |
| att_cmd | input | CW | Attempt command |
| att_data | input | DW | Attempt data |
| att_be | input | BW | Attempt byte enables |
| att_par_err | input | 1 | Computed parity of the attempt's data phase is wrong |
| clr_det | input | 1 | Clear pulse for `par_det_o` |
| clr_dpd | input | 1 | Clear pulse for `dpar_det_o` |
| clr_serr | input | 1 | Clear pulse for `serr_o` |
| trdy_o | output | 1 | Data phase accepted (target ready) |
| retry_o | output | 1 | Attempt answered with retry |
| perr_o | output | 1 | Delayed parity error strobe |
| q_full_o | output | 1 | A delayed write record is queued |
| par_det_o | output | 1 | Sticky: parity error detected on this interface |
| dpar_det_o | output | 1 | Sticky: data parity error reported by target |
| serr_o | output | 1 | Sticky: master timeout system error |

## Verification
The assertions assume three things about the inputs. Pulses on `att_valid`, `wr_load` and `tgt_done` last one cycle. `tmo_limit` changes only while no record is queued. `en_resp_init` and `en_resp_tgt` stay steady between an event and its strobe. The stimulus drives every pulse for a single cycle from a task and moves the timeout limit only after the record has been freed. It also leaves at least four idle cycles after every strobe-producing attempt, except in the deliberate back-to-back case that probes the lost second event.

// File: rtl/dwp_pkg.sv
package dwp_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PEND  = 2'd1,
        S_READY = 2'd2
    } dw_state_e;

    localparam int ST_DET  = 0;
    localparam int ST_DPD  = 1;
    localparam int ST_SERR = 2;
    localparam int ST_N    = 3;

endpackage

// File: rtl/dwp_entry.sv
module dwp_entry #(
    parameter int AW = 32,
    parameter int CW = 4,
    parameter int DW = 32,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [AW-1:0] ld_addr,
    input  logic [CW-1:0] ld_cmd,
    input  logic [DW-1:0] ld_data,
    input  logic [BW-1:0] ld_be,
    input  logic [AW-1:0] cmp_addr,
    input  logic [CW-1:0] cmp_cmd,
    input  logic [DW-1:0] cmp_data,
    input  logic [BW-1:0] cmp_be,
    output logic          hit
);
    localparam int RW = AW + CW + DW + BW;

    logic [RW-1:0] rec_q;
    logic [RW-1:0] cmp_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else if (cap) begin
            rec_q <= {ld_addr, ld_cmd, ld_data, ld_be};
        end
    end

    // Parity is deliberately absent from the compared vector.
    assign cmp_vec = {cmp_addr, cmp_cmd, cmp_data, cmp_be};
    assign hit     = (cmp_vec == rec_q);

    // R1: record only changes on a capture
    p_rec_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap) |-> $stable(rec_q));

endmodule

// File: rtl/dwp_perr_dly.sv
module dwp_perr_dly #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic perr_o
);
    localparam int CNTW = $clog2(DLY + 1);
    localparam logic [CNTW-1:0] DLY_V = CNTW'(DLY);
    localparam logic [CNTW-1:0] ONE_V = CNTW'(1);

    logic [CNTW-1:0] dly_q;
    logic            perr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q  <= '0;
            perr_q <= 1'b0;
        end else begin
            if (arm && dly_q == '0) begin
                dly_q <= DLY_V;
            end else if (dly_q != '0) begin
                dly_q <= dly_q - ONE_V;
            end
            perr_q <= (dly_q == ONE_V);
        end
    end

    assign perr_o = perr_q;

    // R9: strobe lasts one cycle
    p_perr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        perr_q |=> !perr_q);

    // R9: an event arriving mid-count does not restart the delay
    p_event_lost_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && dly_q != '0) |=> (dly_q != DLY_V));

endmodule

// File: rtl/dwp_tmo.sv
module dwp_tmo #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != limit) begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

    assign expired = run && (cnt_q == limit);

    // R10: the count never passes the limit while a record waits
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(restart) && $stable(limit)) |-> (cnt_q <= limit));

endmodule

// File: rtl/dwp_status.sv
module dwp_status #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] bits_o
);
    logic [N-1:0] bits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= (bits_q & ~clr) | set;
        end
    end

    assign bits_o = bits_q;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R11: a set bit stays set until its clear pulse
        p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(bits_q[g]) && !$past(clr[g])) |-> bits_q[g]);
    end

endmodule

// File: rtl/dwr_parity_ctl.sv
module dwr_parity_ctl
    import dwp_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CW       = 4,
    parameter int DW       = 32,
    parameter int BW       = 4,
    parameter int TW       = 16,
    parameter int PERR_DLY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_resp_init,
    input  logic          en_resp_tgt,
    input  logic [TW-1:0] tmo_limit,
    input  logic          wr_load,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_cmd,
    input  logic [DW-1:0] wr_data,
    input  logic [BW-1:0] wr_be,
    input  logic          tgt_done,
    input  logic          tgt_perr,
    input  logic          att_valid,
    input  logic [AW-1:0] att_addr,
    input  logic [CW-1:0] att_cmd,
    input  logic [DW-1:0] att_data,
    input  logic [BW-1:0] att_be,
    input  logic          att_par_err,
    input  logic          clr_det,
    input  logic          clr_dpd,
    input  logic          clr_serr,
    output logic          trdy_o,
    output logic          retry_o,
    output logic          perr_o,
    output logic          q_full_o,
    output logic          par_det_o,
    output logic          dpar_det_o,
    output logic          serr_o
);
    dw_state_e state_q, state_d;

    logic hit, expired, fwd_q;
    logic load_ok, tgt_ok, complete, perr_retry, retry_ev, tmo_fire, arm;
    logic trdy_q, retry_q;
    logic [ST_N-1:0] st_set, st_clr, st_bits;

    // ---------------- event decode ----------------
    assign load_ok    = (state_q == S_IDLE) && wr_load;
    assign tgt_ok     = (state_q == S_PEND) && tgt_done;
    assign complete   = (state_q == S_READY) && att_valid && hit && !att_par_err;
    assign perr_retry = (state_q == S_READY) && att_valid && hit && att_par_err;
    assign retry_ev   = att_valid && !complete && !perr_retry;
    assign tmo_fire   = expired && !complete && !perr_retry;
    assign arm        = (perr_retry && en_resp_init)
                      || (complete && fwd_q && en_resp_init && en_resp_tgt);

    // ---------------- sub-blocks ----------------
    dwp_entry #(.AW(AW), .CW(CW), .DW(DW), .BW(BW)) u_entry (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (load_ok),
        .ld_addr  (wr_addr),
        .ld_cmd   (wr_cmd),
        .ld_data  (wr_data),
        .ld_be    (wr_be),
        .cmp_addr (att_addr),
        .cmp_cmd  (att_cmd),
        .cmp_data (att_data),
        .cmp_be   (att_be),
        .hit      (hit)
    );

    dwp_tmo #(.TW(TW)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load_ok || perr_retry),
        .run     (state_q != S_IDLE),
        .limit   (tmo_limit),
        .expired (expired)
    );

    dwp_perr_dly #(.DLY(PERR_DLY)) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm),
        .perr_o (perr_o)
    );

    always_comb begin
        st_set          = '0;
        st_set[ST_DET]  = perr_retry;
        st_set[ST_DPD]  = tgt_ok && tgt_perr && en_resp_tgt;
        st_set[ST_SERR] = tmo_fire;
        st_clr          = '0;
        st_clr[ST_DET]  = clr_det;
        st_clr[ST_DPD]  = clr_dpd;
        st_clr[ST_SERR] = clr_serr;
    end

    dwp_status #(.N(ST_N)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (st_set),
        .clr    (st_clr),
        .bits_o (st_bits)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (load_ok) state_d = S_PEND;          // load
            end
            S_PEND: begin
                if (tmo_fire)      state_d = S_IDLE;    // expire
                else if (tgt_done) state_d = S_READY;   // target_done
            end
            S_READY: begin
                if (complete || tmo_fire) state_d = S_IDLE; // complete / expire
            end
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trdy_q  <= 1'b0;
            retry_q <= 1'b0;
            fwd_q   <= 1'b0;
        end else begin
            trdy_q  <= complete || perr_retry;
            retry_q <= retry_ev;
            if (load_ok) begin
                fwd_q <= 1'b0;
            end else if (tgt_ok) begin
                fwd_q <= tgt_perr;
            end
        end
    end

    assign trdy_o     = trdy_q;
    assign retry_o    = retry_q;
    assign q_full_o   = (state_q != S_IDLE);
    assign par_det_o  = st_bits[ST_DET];
    assign dpar_det_o = st_bits[ST_DPD];
    assign serr_o     = st_bits[ST_SERR];

    // ---------------- assertions ----------------
    p_trdy_retry_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(trdy_o && retry_o));

    p_load_fills_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_load && !q_full_o) |=> q_full_o);

    p_perr_after_trdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> $past(trdy_o, 2));

    p_det_keeps_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_det_o) |-> (q_full_o && trdy_o));

    p_serr_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(serr_o) |-> !q_full_o);

    p_retry_no_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_o && $past(q_full_o) && !$rose(serr_o)) |-> q_full_o);

endmodule

// File: tb/dwr_parity_ctl_bench.sv
module dwr_parity_ctl_bench;

    localparam int AW = 32, CW = 4, DW = 32, BW = 4, TW = 16;
    localparam int SIG_TRDY = 0, SIG_RETRY = 1, SIG_PERR = 2, SIG_Q = 3;
    localparam int SIG_DET = 4, SIG_DPD = 5, SIG_SERR = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_resp_init, en_resp_tgt;
    logic [TW-1:0] tmo_limit;
    logic wr_load, tgt_done, tgt_perr, att_valid, att_par_err;
    logic [AW-1:0] wr_addr, att_addr;
    logic [CW-1:0] wr_cmd, att_cmd;
    logic [DW-1:0] wr_data, att_data;
    logic [BW-1:0] wr_be, att_be;
    logic clr_det, clr_dpd, clr_serr;
    logic trdy_o, retry_o, perr_o, q_full_o, par_det_o, dpar_det_o, serr_o;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit mon_on = 1'b0;

    typedef struct {
        int    cyc;
        int    sig;
        bit    val;
        string req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dwr_parity_ctl u_dwr_parity_ctl (
        .clk(clk), .rst_n(rst_n), .en_resp_init(en_resp_init), .en_resp_tgt(en_resp_tgt),
        .tmo_limit(tmo_limit), .wr_load(wr_load), .wr_addr(wr_addr), .wr_cmd(wr_cmd),
        .wr_data(wr_data), .wr_be(wr_be), .tgt_done(tgt_done), .tgt_perr(tgt_perr),
        .att_valid(att_valid), .att_addr(att_addr), .att_cmd(att_cmd), .att_data(att_data),
        .att_be(att_be), .att_par_err(att_par_err), .clr_det(clr_det), .clr_dpd(clr_dpd),
        .clr_serr(clr_serr), .trdy_o(trdy_o), .retry_o(retry_o), .perr_o(perr_o),
        .q_full_o(q_full_o), .par_det_o(par_det_o), .dpar_det_o(dpar_det_o), .serr_o(serr_o)
    );

    function automatic bit sig_val(input int s);
        case (s)
            SIG_TRDY:  return trdy_o;
            SIG_RETRY: return retry_o;
            SIG_PERR:  return perr_o;
            SIG_Q:     return q_full_o;
            SIG_DET:   return par_det_o;
            SIG_DPD:   return dpar_det_o;
            default:   return serr_o;
        endcase
    endfunction

    function automatic string sig_name(input int s);
        case (s)
            SIG_TRDY:  return "trdy";
            SIG_RETRY: return "retry";
            SIG_PERR:  return "perr";
            SIG_Q:     return "q_full";
            SIG_DET:   return "par_det";
            SIG_DPD:   return "dpar_det";
            default:   return "serr";
        endcase
    endfunction

    task automatic judge(input int s, input bit exp, input string req);
        total++;
        if (sig_val(s) !== exp) begin
            bad++;
            $display("FAIL %s %s cyc=%0d actual=%0b expected=%0b",
                     req, sig_name(s), cyc, sig_val(s), exp);
        end
    endtask

    task automatic push(input int c, input int s, input bit v, input string req);
        exp_t e;
        e.cyc = c; e.sig = s; e.val = v; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: compares scoreboard items as their cycle arrives
    always @(negedge clk) begin
        if (mon_on) begin
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].cyc == cyc) begin
                    judge(sb[i].sig, sb[i].val, sb[i].req);
                    sb.delete(i);
                end
            end
        end
    end

    task automatic drop_pulses();
        wr_load = 0; tgt_done = 0; tgt_perr = 0; att_valid = 0; att_par_err = 0;
        clr_det = 0; clr_dpd = 0; clr_serr = 0;
    endtask

    task automatic gap(input int k);
        repeat (k) begin
            @(negedge clk);
            drop_pulses();
        end
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [CW-1:0] c,
                        input logic [DW-1:0] d, input logic [BW-1:0] b,
                        input bit exp_q, input string req);
        @(negedge clk);
        drop_pulses();
        wr_load = 1; wr_addr = a; wr_cmd = c; wr_data = d; wr_be = b;
        push(cyc + 1, SIG_Q, exp_q, req);
    endtask

    task automatic target(input bit pe);
        @(negedge clk);
        drop_pulses();
        tgt_done = 1; tgt_perr = pe;
    endtask

    // pm: 0 no strobe check, 1 strobe expected, 2 quiet both cycles, 3 quiet at +3 only
    task automatic attempt(input logic [AW-1:0] a, input logic [CW-1:0] c,
                           input logic [DW-1:0] d, input logic [BW-1:0] b,
                           input bit pe, input bit e_trdy, input bit e_retry,
                           input int pm, input bit e_q, input string req);
        int n;
        @(negedge clk);
        drop_pulses();
        n = cyc;
        att_valid = 1; att_addr = a; att_cmd = c; att_data = d; att_be = b; att_par_err = pe;
        push(n + 1, SIG_TRDY, e_trdy, req);
        push(n + 1, SIG_RETRY, e_retry, req);
        push(n + 1, SIG_Q, e_q, req);
        case (pm)
            1: begin push(n + 2, SIG_PERR, 1'b0, req); push(n + 3, SIG_PERR, 1'b1, req); end
            2: begin push(n + 2, SIG_PERR, 1'b0, req); push(n + 3, SIG_PERR, 1'b0, req); end
            3: push(n + 3, SIG_PERR, 1'b0, req);
            default: ;
        endcase
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog cyc=%0d actual=running expected=finished", cyc);
        finish_up();
    end

    localparam logic [AW-1:0] A1 = 32'h1000_0040;
    localparam logic [CW-1:0] C1 = 4'h7;
    localparam logic [DW-1:0] D1 = 32'hCAFE_1234;
    localparam logic [BW-1:0] B1 = 4'hF;

    initial begin
        en_resp_init = 1; en_resp_tgt = 1; tmo_limit = 16'd1000;
        wr_addr = '0; wr_cmd = '0; wr_data = '0; wr_be = '0;
        att_addr = '0; att_cmd = '0; att_data = '0; att_be = '0;
        drop_pulses();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        mon_on = 1;
        // R12 reset state
        for (int s = 0; s <= SIG_SERR; s++) judge(s, 1'b0, "R12");

        // R3: attempt with nothing queued
        attempt(A1, C1, D1, B1, 0, 0, 1, 2, 0, "R3");
        gap(3);
        // R1: load, then an ignored second load
        load(A1, C1, D1, B1, 1, "R1");
        gap(2);
        load(32'hDEAD_0000, 4'h3, 32'h0, 4'h1, 1, "R1");
        gap(2);
        // R3: before target completion
        attempt(A1, C1, D1, B1, 0, 0, 1, 2, 1, "R3");
        gap(3);
        target(0);
        gap(2);
        // R2: each field differing alone
        attempt(A1 ^ 32'h4, C1, D1, B1, 0, 0, 1, 2, 1, "R2");
        gap(3);
        attempt(A1, C1 ^ 4'h1, D1, B1, 0, 0, 1, 2, 1, "R2");
        gap(3);
        attempt(A1, C1, D1 ^ 32'h8000_0000, B1, 0, 0, 1, 2, 1, "R2");
        gap(3);
        attempt(A1, C1, D1, 4'h7, 0, 0, 1, 2, 1, "R2");
        gap(3);
        // R4 R5 R6: parity error on matching attempt
        attempt(A1, C1, D1, B1, 1, 1, 0, 1, 1, "R4 R5");
        push(cyc + 1, SIG_DET, 1'b1, "R6");
        gap(5);
        // R11: clear
        @(negedge clk); drop_pulses(); clr_det = 1;
        push(cyc + 1, SIG_DET, 1'b0, "R11");
        gap(2);
        // R5 R6: response disabled
        en_resp_init = 0;
        attempt(A1, C1, D1, B1, 1, 1, 0, 2, 1, "R5");
        push(cyc + 1, SIG_DET, 1'b1, "R6");
        gap(5);
        en_resp_init = 1;
        // R2 R4: clean completion frees entry, no strobe
        attempt(A1, C1, D1, B1, 0, 1, 0, 2, 0, "R2 R4");
        gap(5);

        // R7 R8: forwarded target error with both enables
        load(32'h2000_0000, 4'hB, 32'h5555_AAAA, 4'h3, 1, "R1");
        gap(1);
        target(1);
        push(cyc + 1, SIG_DPD, 1'b1, "R7");
        gap(2);
        attempt(32'h2000_0000, 4'hB, 32'h5555_AAAA, 4'h3, 0, 1, 0, 1, 0, "R8");
        gap(5);
        @(negedge clk); drop_pulses(); clr_dpd = 1;
        push(cyc + 1, SIG_DPD, 1'b0, "R11");
        gap(2);
        // R7 R8: target-side enable off
        en_resp_tgt = 0;
        load(32'h3000_0010, 4'h6, 32'h0F0F_0F0F, 4'hC, 1, "R1");
        gap(1);
        target(1);
        push(cyc + 1, SIG_DPD, 1'b0, "R7");
        gap(2);
        attempt(32'h3000_0010, 4'h6, 32'h0F0F_0F0F, 4'hC, 0, 1, 0, 2, 0, "R8");
        gap(5);
        en_resp_tgt = 1;

        // R9: second event during delay is lost
        load(32'h4000_0000, 4'h7, 32'h1111_2222, 4'hF, 1, "R1");
        gap(1);
        target(0);
        gap(2);
        attempt(32'h4000_0000, 4'h7, 32'h1111_2222, 4'hF, 1, 1, 0, 1, 1, "R9");
        attempt(32'h4000_0000, 4'h7, 32'h1111_2222, 4'hF, 1, 1, 0, 3, 1, "R9");
        gap(6);
        attempt(32'h4000_0000, 4'h7, 32'h1111_2222, 4'hF, 0, 1, 0, 2, 0, "R4");
        gap(5);

        // R10: master timeout
        tmo_limit = 16'd6;
        load(32'h5000_0000, 4'h7, 32'h7777_0000, 4'hF, 1, "R10");
        push(cyc + 7, SIG_Q, 1'b1, "R10");
        push(cyc + 8, SIG_Q, 1'b0, "R10");
        push(cyc + 7, SIG_SERR, 1'b0, "R10");
        push(cyc + 8, SIG_SERR, 1'b1, "R10");
        gap(10);
        attempt(32'h5000_0000, 4'h7, 32'h7777_0000, 4'hF, 0, 0, 1, 2, 0, "R10");
        gap(4);
        @(negedge clk); drop_pulses(); clr_serr = 1;
        push(cyc + 1, SIG_SERR, 1'b0, "R11");
        gap(4);

        mon_on = 0;
        foreach (sb[i]) begin
            total++; bad++;
            $display("FAIL %s %s unchecked cyc=%0d actual=none expected=%0b",
                     sb[i].req, sig_name(sb[i].sig), sb[i].cyc, sb[i].val);
        end
        finish_up();
    end

endmodule